// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block connects a 32-bit register datapath to a byte-addressed data memory port that is one word wide. For each request it adds a sign-extended 16-bit displacement to a base register value to form a byte address. It then checks that address against the access size. For a store, it places the source data onto the correct byte lanes and raises only the write enables of the bytes the access covers. For a load, it picks the addressed byte or halfword out of the returned memory word and widens it with zeros to 32 bits.

Byte lanes follow big-endian order. Within a word, the byte at the lowest address occupies the most significant bits. The memory array is expected to return read data in the same cycle that its address is presented. Writes take effect on the rising clock edge. A request whose address is misaligned does not touch memory. It produces a one-cycle fault indication in place of a response.

A small response state machine takes one request per cycle. Its state holds the outcome of the previous cycle's request. The three states are `ST_IDLE` (no response), `ST_LOAD_DONE` (load data valid) and `ST_FAULT` (misaligned request). Every state moves on each clock edge to the state chosen by the current request:
- `GO_FAULT` is taken on a misaligned request.
- `GO_LOAD` is taken on an aligned load.
- `GO_IDLE` is taken on a store or when no request is present.

Top module: `lsu_lane_unit`

## Requirements
- R1: The byte address is `req_base` plus `req_offset` sign-extended to 32 bits. `mem_addr` carries that address with its two low bits cleared whenever memory is accessed.
- R2: Lanes are big-endian. The byte at address offset k within a word (k = 0..3) lives in `mem_rdata`/`mem_wdata` bits [31-8k:24-8k]. `mem_we[i]` enables bits [8i+7:8i], so offset k maps to `mem_we[3-k]`.
- R3: A word access (`req_size` 2'b10, with 2'b11 treated the same) faults when either of the two low address bits is set.
- R4: A halfword access (`req_size` 2'b01) faults when address bit 0 is set.
- R5: A byte access (`req_size` 2'b00) never faults.
- R6: Byte and halfword loads return the selected bits zero-extended to 32 bits. A halfword at offset 0 comes from bits [31:16] and one at offset 2 comes from bits [15:0].
- R7: A store drives `mem_we` as follows: 4'b1111 for a word, 4'b1100 or 4'b0011 for a halfword at offset 0 or 2, and a single bit for a byte. The source byte or halfword is replicated across all lanes of `mem_wdata`, so bytes outside the enabled lanes stay unchanged.
- R8: A misaligned request drives `mem_we` to zero and `mem_re` low. In the next cycle only, it sets `fault` high, holds `load_valid` low and returns `load_data` as zero.
- R9: After an aligned load, `load_valid` is high with the data in the following cycle. After a store or an idle cycle, `load_valid` is low.
- R10: While reset is applied and after it is released, `load_valid`, `fault` and `load_data` are zero until the first request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source data (low bits used for sub-word stores) |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Memory read word, same cycle as `mem_addr` |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Zero-extended load result |
| fault | output | 1 | Misaligned-request pulse |

## Verification
The bench aims at every byte and halfword offset within a word. A unit that reverses the lane order would return 0x67 in place of 0x01 at the first byte of a stored 0x01234567, or would overwrite the wrong neighbour on a sub-word store. It also aims at addresses that are misaligned by exactly one bit for each size. A check that used the wrong mask would either fault on a legal halfword or let a misaligned word write memory. Negative displacements are driven to catch a design that zero-extends the offset, which would produce an address 64 KiB too high. Randomly mixed stores and loads, compared with a byte-level reference memory, expose sub-word loads that carry stale upper bits.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'b00,
        ST_LOAD_DONE = 2'b01,
        ST_FAULT     = 2'b10
    } rsp_state_e;

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
    import lsu_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int OFF_W     = 16,
    parameter int LANE_BITS = 2
) (
    input  logic [ADDR_W-1:0]    base,
    input  logic [OFF_W-1:0]     offset,
    input  logic [1:0]           size,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [LANE_BITS-1:0] lane_off,
    output logic                 misalign
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] offset_sx;
    logic [ADDR_W-1:0] eff_addr;

    assign offset_sx = {{EXT_W{offset[OFF_W-1]}}, offset};
    assign eff_addr  = base + offset_sx;
    assign lane_off  = eff_addr[LANE_BITS-1:0];
    assign word_addr = {eff_addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}};

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = eff_addr[0];
            default: misalign = |eff_addr[LANE_BITS-1:0];
        endcase
    end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  enable,
    input  logic [1:0]            size,
    input  logic [$clog2(DATA_W/8)-1:0] lane_off,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W/8-1:0]   we,
    output logic [DATA_W-1:0]     lane_data
);
    localparam int LANES = DATA_W / 8;
    localparam int LB    = $clog2(LANES);
    localparam int HALVES = LANES / 2;

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: lane_data = {LANES{wdata[7:0]}};
            SZ_HALF: lane_data = {HALVES{wdata[15:0]}};
            default: lane_data = wdata;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int BOFF = LANES - 1 - i;
        localparam logic [LB-1:0] BOFF_V = BOFF[LB-1:0];
        logic hit;
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: hit = (lane_off == BOFF_V);
                SZ_HALF: hit = (lane_off[LB-1:1] == BOFF_V[LB-1:1]);
                default: hit = 1'b1;
            endcase
        end
        assign we[i] = enable & hit;
    end
endmodule

// File: rtl/lsu_load_lanes.sv
module lsu_load_lanes
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                  size,
    input  logic [$clog2(DATA_W/8)-1:0] lane_off,
    input  logic [DATA_W-1:0]           rdata,
    output logic [DATA_W-1:0]           ext_data
);
    localparam int LANES  = DATA_W / 8;
    localparam int LB     = $clog2(LANES);
    localparam int HALVES = LANES / 2;

    logic [7:0]  byte_at [LANES];
    logic [15:0] half_at [HALVES];

    for (genvar k = 0; k < LANES; k++) begin : g_byte
        assign byte_at[k] = rdata[DATA_W-1-8*k -: 8];
    end
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        assign half_at[h] = rdata[DATA_W-1-16*h -: 16];
    end

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: ext_data = {{(DATA_W-8){1'b0}}, byte_at[lane_off]};
            SZ_HALF: ext_data = {{(DATA_W-16){1'b0}}, half_at[lane_off[LB-1:1]]};
            default: ext_data = rdata;
        endcase
    end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
    import lsu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_store,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_base,
    input  logic [OFF_W-1:0]    req_offset,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_re,
    output logic [DATA_W/8-1:0] mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                load_valid,
    output logic [DATA_W-1:0]   load_data,
    output logic                fault
);
    localparam int LANES = DATA_W / 8;
    localparam int LB    = $clog2(LANES);

    logic [LB-1:0]     lane_off;
    logic              misalign_w;
    logic [DATA_W-1:0] ext_data;
    logic              store_go;

    rsp_state_e        state_q, state_d;
    logic [DATA_W-1:0] data_q;

    lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_BITS(LB)) u_addr (
        .base      (req_base),
        .offset    (req_offset),
        .size      (req_size),
        .word_addr (mem_addr),
        .lane_off  (lane_off),
        .misalign  (misalign_w)
    );

    assign store_go = req_valid & req_store & ~misalign_w;
    assign mem_re   = req_valid & ~req_store & ~misalign_w;

    lsu_store_lanes #(.DATA_W(DATA_W)) u_store (
        .enable    (store_go),
        .size      (req_size),
        .lane_off  (lane_off),
        .wdata     (req_wdata),
        .we        (mem_we),
        .lane_data (mem_wdata)
    );

    lsu_load_lanes #(.DATA_W(DATA_W)) u_load (
        .size     (req_size),
        .lane_off (lane_off),
        .rdata    (mem_rdata),
        .ext_data (ext_data)
    );

    // Next-state: GO_FAULT, GO_LOAD, GO_IDLE from any state
    always_comb begin
        if (req_valid && misalign_w)      state_d = ST_FAULT;
        else if (req_valid && !req_store) state_d = ST_LOAD_DONE;
        else                              state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            data_q  <= (state_d == ST_LOAD_DONE) ? ext_data : '0;
        end
    end

    always_comb begin
        load_valid = 1'b0;
        fault      = 1'b0;
        unique case (state_q)
            ST_IDLE:      ;
            ST_LOAD_DONE: load_valid = 1'b1;
            ST_FAULT:     fault      = 1'b1;
            default:      ;
        endcase
    end
    assign load_data = data_q;

    // R8: misaligned request touches no memory
    a_r8_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && misalign_w) |-> (mem_we == '0 && !mem_re));
    // R8: fault only follows a misaligned request
    a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && misalign_w) |=> !fault);
    // R8: zero data on fault
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (load_data == '0 && !load_valid));
    // R9: aligned load answers next cycle
    a_r9_load_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && !misalign_w) |=> (load_valid && !fault));
    // R5: byte access never faults
    a_r5_byte_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |=> !fault);
    // R7: byte store enables one lane, halfword two
    a_r7_byte_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'b00) |-> ($countones(mem_we) == 1));
    a_r7_half_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go && req_size == 2'b01) |-> ($countones(mem_we) == 2));
endmodule

// File: tb/lsu_lane_unit_bench.sv
`timescale 1ns/1ps
module lsu_lane_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_store = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [31:0] req_base = '0, req_wdata = '0;
    logic [15:0] req_offset = '0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data;
    logic        mem_re, load_valid, fault;
    logic [3:0]  mem_we;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] mem [0:63];
    logic [7:0]  ref_mem [0:255];

    always #10 clk = ~clk;

    lsu_lane_unit u_lsu_lane_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_base(req_base), .req_offset(req_offset),
        .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .load_valid(load_valid), .load_data(load_data), .fault(fault)
    );

    assign mem_rdata = mem[mem_addr[7:2]];
    always @(posedge clk) begin
        for (int i = 0; i < 4; i++)
            if (mem_we[i]) mem[mem_addr[7:2]][8*i +: 8] <= mem_wdata[8*i +: 8];
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_mis(logic [1:0] sz, logic [31:0] ea);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return ea[0];
        return |ea[1:0];
    endfunction

    function automatic logic [3:0] exp_we(logic [1:0] sz, logic [31:0] ea);
        if (sz == 2'b00) return 4'b0001 << (3 - ea[1:0]);
        if (sz == 2'b01) return ea[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_load(logic [1:0] sz, logic [7:0] a);
        if (sz == 2'b00) return {24'h0, ref_mem[a]};
        if (sz == 2'b01) return {16'h0, ref_mem[a], ref_mem[a+8'd1]};
        return {ref_mem[a], ref_mem[a+8'd1], ref_mem[a+8'd2], ref_mem[a+8'd3]};
    endfunction

    function automatic string mis_tag(logic [1:0] sz);
        if (sz == 2'b00) return "R5";
        if (sz == 2'b01) return "R4";
        return "R3";
    endfunction

    // Called at a falling edge; returns at the next falling edge
    task automatic access(bit st, logic [1:0] sz, logic [31:0] base,
                          logic [15:0] off, logic [31:0] wd);
        logic [31:0] ea;
        logic [31:0] exp_d;
        bit mis;
        ea  = base + {{16{off[15]}}, off};
        mis = exp_mis(sz, ea);
        exp_d = exp_load(sz, ea[7:0]);
        req_valid = 1'b1; req_store = st; req_size = sz;
        req_base = base; req_offset = off; req_wdata = wd;
        #1;
        if (mis) begin
            chk("R8 we on fault", {27'h0, mem_re, mem_we}, 32'h0);
        end else begin
            chk("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
            if (st) begin
                chk("R7 write enables", {28'h0, mem_we}, {28'h0, exp_we(sz, ea)});
                chk("R7 no read on store", {31'h0, mem_re}, 32'h0);
            end else begin
                chk("R9 read strobe", {31'h0, mem_re}, 32'h1);
            end
        end
        @(posedge clk);
        if (st && !mis) begin
            if (sz == 2'b00) ref_mem[ea[7:0]] = wd[7:0];
            else if (sz == 2'b01) begin
                ref_mem[ea[7:0]] = wd[15:8];
                ref_mem[ea[7:0] + 8'd1] = wd[7:0];
            end else
                for (int k = 0; k < 4; k++)
                    ref_mem[ea[7:0] + 8'(k)] = wd[31-8*k -: 8];
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk({mis_tag(sz), " fault flag"}, {31'h0, fault}, {31'h0, mis});
        chk("R9 load_valid", {31'h0, load_valid}, {31'h0, (!st && !mis)});
        if (mis)
            chk("R8 data on fault", load_data, 32'h0);
        else if (!st)
            chk((sz == 2'b10 || sz == 2'b11) ? "R2 word load" : "R6 zero-extended load",
                load_data, exp_d);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) mem[i] = '0;
        for (int i = 0; i < 256; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk("R10 reset valid", {31'h0, load_valid}, 32'h0);
        chk("R10 reset fault", {31'h0, fault}, 32'h0);
        chk("R10 reset data", load_data, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", {30'h0, load_valid, fault}, 32'h0);

        // R2: big-endian placement of 0x01234567 at 0x100
        access(1, 2'b10, 32'h100, 16'h0000, 32'h01234567);
        access(0, 2'b00, 32'h100, 16'h0000, 0);
        chk("R2 byte0", load_data, 32'h01);
        access(0, 2'b00, 32'h100, 16'h0003, 0);
        chk("R2 byte3", load_data, 32'h67);
        access(0, 2'b01, 32'h100, 16'h0000, 0);
        chk("R6 half0", load_data, 32'h0123);
        access(0, 2'b01, 32'h100, 16'h0002, 0);
        chk("R6 half2", load_data, 32'h4567);
        // R1: negative displacement
        access(0, 2'b10, 32'h108, 16'hFFF8, 0);
        chk("R1 negative offset", load_data, 32'h01234567);
        // R7: byte and halfword stores keep neighbours
        access(1, 2'b00, 32'h101, 16'h0000, 32'hFFFF_FFAB);
        access(0, 2'b10, 32'h100, 16'h0000, 0);
        chk("R7 byte store", load_data, 32'h01AB4567);
        access(1, 2'b01, 32'h100, 16'h0002, 32'hFFFF_BEEF);
        access(0, 2'b10, 32'h100, 16'h0000, 0);
        chk("R7 half store", load_data, 32'h01ABBEEF);
        // R3/R4/R5/R8: alignment corners
        access(0, 2'b10, 32'h102, 16'h0000, 0);
        access(1, 2'b10, 32'h101, 16'h0000, 32'hDEADBEEF);
        access(1, 2'b01, 32'h103, 16'h0000, 32'h1234);
        access(0, 2'b01, 32'h101, 16'h0000, 0);
        access(0, 2'b00, 32'h103, 16'h0000, 0);
        access(0, 2'b11, 32'h100, 16'h0001, 0);
        access(0, 2'b10, 32'h100, 16'h0000, 0);
        chk("R8 memory untouched by faults", load_data, 32'h01ABBEEF);

        for (int n = 0; n < 600; n++) begin
            access(bit'($urandom % 2), 2'($urandom % 4), $urandom,
                   16'($urandom), $urandom);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule